// File: doc/BRIEF.md
# Bidirectional Reset Pin Controller

This block turns a slow, noisy external reset level into a clean internal reset and, in the other direction, pushes a fixed-length high pulse back out on the same pin when the chip's watchdog expires. The incoming pin level is first passed through a flop synchronizer. It then has to stay high for a whole qualification window of machine cycles before the internal reset is raised. Any low sample inside that window starts the count again.

A single-cycle expiry strobe from the watchdog opens a fixed-length reset window. The internal reset is held for the whole window in every case. The pin drive enable is raised for that same window unless the pulse-suppress control bit was set when the strobe arrived. The block's own flops are cleared by an asynchronous power-on reset. The surrounding logic keeps the suppress bit at 0 after reset, so the pulse is enabled by default.

Top module: `rstc_top`

## Requirements
- R1: While `por_ni` is low, and right after it is released, `rst_int_o` and `rst_drv_o` are both 0.
- R2: With default parameters (12 clocks per machine cycle, 2 machine cycles, 2 synchronizer stages), once `rst_pin_i` has been sampled high on 24 consecutive rising edges, `rst_int_o` goes high on the second edge after the 24th sample. If only 23 consecutive high samples are taken, it never goes high.
- R3: A single low sample of `rst_pin_i` restarts qualification. A run of 20 highs, one low and then 23 highs never asserts `rst_int_o`. A run of 20 highs, one low and then 24 highs does assert it.
- R4: When the qualified pin reset is the only source, `rst_int_o` goes low on the third rising edge that samples `rst_pin_i` low.
- R5: A `wdt_expire_i` strobe sampled while `drv_disable_i` is 0 makes `rst_drv_o` high from that edge on, for exactly 98 consecutive clock cycles.
- R6: A `wdt_expire_i` strobe sampled while `drv_disable_i` is 1 leaves `rst_drv_o` at 0. `rst_int_o` is still high for 98 cycles.
- R7: `rst_int_o` is high in every cycle in which `rst_drv_o` is high.
- R8: A new strobe that arrives during an active window restarts the window, so the new window lasts a full 98 cycles from the new strobe.
- R9: `drv_disable_i` is sampled only on the strobe edge. Changing it during a window does not shorten or stop the drive pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| por_ni | input | 1 | Asynchronous power-on reset for this block, active low |
| rst_pin_i | input | 1 | Raw level read back from the reset pin |
| wdt_expire_i | input | 1 | One-cycle watchdog expiry strobe |
| drv_disable_i | input | 1 | Suppress bit from the auxiliary control register; 1 blocks the pin pulse |
| rst_int_o | output | 1 | Internal reset, active high |
| rst_drv_o | output | 1 | Drive enable for the reset pin, high drives it high |

## Verification
Most faults in the qualification counter or the synchronizer chain show up as an off-by-one edge: the internal reset rises one cycle early or late around the 24th high sample, or a 23-sample run slips through. Pattern tests that land exactly on those edges expose this within a few dozen cycles. A wrong window counter or a wrong latched enable shows at the pin as a drive pulse of the wrong length, as a drive that ignores or wrongly follows the suppress bit, or as a drive while the internal reset is low. The bench measures every window edge to the cycle, and it also compares both outputs cycle by cycle against an independent model over a long random pin and strobe sequence.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
   // width needed to hold the values 0..n
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic por_ni,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("rstc_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk_i or negedge por_ni) begin
               if (!por_ni) chain_q[i] <= 1'b0;
               else         chain_q[i] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge por_ni) begin
               if (!por_ni) chain_q[i] <= 1'b0;
               else         chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstc_qual.sv
module rstc_qual #(
   parameter int unsigned CLKS_PER_MC = 12,
   parameter int unsigned HOLD_MC     = 2
) (
   input  logic clk_i,
   input  logic por_ni,
   input  logic level_i,
   output logic hit_o
);
   import rstc_pkg::*;
   localparam int unsigned HOLD_CLKS = CLKS_PER_MC * HOLD_MC;
   localparam int unsigned QW        = cnt_w(HOLD_CLKS);

   generate
      if (CLKS_PER_MC == 0 || HOLD_MC == 0) begin : g_bad
         $error("rstc_qual: qualification window must be non-zero");
      end
   endgenerate

   logic [QW-1:0] run_q;

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni)                     run_q <= '0;
      else if (!level_i)               run_q <= '0;
      else if (run_q != QW'(HOLD_CLKS)) run_q <= run_q + 1'b1;
   end

   assign hit_o = (run_q == QW'(HOLD_CLKS));

   // R3: a low sample always clears qualification on the next edge
   a_r3_low_clears : assert property (@(posedge clk_i) disable iff (!por_ni)
      !level_i |=> !hit_o);
   // R2: qualification can only be reached after a high sample
   a_r2_rise_needs_high : assert property (@(posedge clk_i) disable iff (!por_ni)
      (!hit_o && !level_i) |=> !hit_o);
endmodule

// File: rtl/rstc_pulse.sv
module rstc_pulse #(
   parameter int unsigned PULSE_CLKS = 98
) (
   input  logic clk_i,
   input  logic por_ni,
   input  logic start_i,
   input  logic dis_i,
   output logic busy_o,
   output logic drv_o
);
   import rstc_pkg::*;
   localparam int unsigned PW = cnt_w(PULSE_CLKS);

   generate
      if (PULSE_CLKS == 0) begin : g_bad
         $error("rstc_pulse: PULSE_CLKS must be non-zero");
      end
   endgenerate

   logic [PW-1:0] left_q;
   logic          en_q;

   always_ff @(posedge clk_i or negedge por_ni) begin
      if (!por_ni) begin
         left_q <= '0;
         en_q   <= 1'b0;
      end else if (start_i) begin
         left_q <= PW'(PULSE_CLKS);
         en_q   <= !dis_i;
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign busy_o = (left_q != '0);
   assign drv_o  = busy_o && en_q;

   // R5: an enabled strobe starts the drive on the next cycle
   a_r5_start_drives : assert property (@(posedge clk_i) disable iff (!por_ni)
      (start_i && !dis_i) |=> drv_o);
   // R6: a suppressed strobe never drives
   a_r6_suppressed : assert property (@(posedge clk_i) disable iff (!por_ni)
      (start_i && dis_i) |=> (!drv_o && busy_o));
   // R9: without a new strobe the drive can only end together with the window
   a_r9_hold_enable : assert property (@(posedge clk_i) disable iff (!por_ni)
      (drv_o && !start_i) |=> (drv_o || !busy_o));
endmodule

// File: rtl/rstc_top.sv
module rstc_top #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CLKS_PER_MC = 12,
   parameter int unsigned HOLD_MC     = 2,
   parameter int unsigned PULSE_CLKS  = 98
) (
   input  logic clk_i,
   input  logic por_ni,
   input  logic rst_pin_i,
   input  logic wdt_expire_i,
   input  logic drv_disable_i,
   output logic rst_int_o,
   output logic rst_drv_o
);
   logic pin_s;
   logic pin_hit;
   logic wdt_busy;

   rstc_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i  (clk_i),
      .por_ni (por_ni),
      .d_i    (rst_pin_i),
      .q_o    (pin_s)
   );

   rstc_qual #(.CLKS_PER_MC(CLKS_PER_MC), .HOLD_MC(HOLD_MC)) i_qual (
      .clk_i   (clk_i),
      .por_ni  (por_ni),
      .level_i (pin_s),
      .hit_o   (pin_hit)
   );

   rstc_pulse #(.PULSE_CLKS(PULSE_CLKS)) i_pulse (
      .clk_i   (clk_i),
      .por_ni  (por_ni),
      .start_i (wdt_expire_i),
      .dis_i   (drv_disable_i),
      .busy_o  (wdt_busy),
      .drv_o   (rst_drv_o)
   );

   assign rst_int_o = pin_hit || wdt_busy;

   // R7: the pin is never driven without the internal reset
   a_r7_drv_in_reset : assert property (@(posedge clk_i) disable iff (!por_ni)
      rst_drv_o |-> rst_int_o);
   // R4: a low synchronized pin with no watchdog window releases reset next cycle
   a_r4_release : assert property (@(posedge clk_i) disable iff (!por_ni)
      (!pin_s && !wdt_busy && !wdt_expire_i) |=> !rst_int_o);
   // R1: immediately after power-on reset both outputs are low
   a_r1_por_quiet : assert property (@(posedge clk_i)
      $rose(por_ni) |-> (!rst_int_o && !rst_drv_o));
endmodule

// File: tb/test_rstc_top.sv
module test_rstc_top;
   localparam int QUAL  = 24;
   localparam int PULSE = 98;

   logic clk = 1'b0;
   logic por_n = 1'b0;
   logic pin = 1'b0, wdt = 1'b0, dis = 1'b0;
   logic rst_int, rst_drv;
   int   checks = 0, errors = 0;
   bit   done = 0;

   // independent expectation state
   bit m_p1, m_p2, m_en;
   int m_run, m_rem;

   always #5 clk = ~clk;

   rstc_top i_rstc_top (
      .clk_i(clk), .por_ni(por_n), .rst_pin_i(pin), .wdt_expire_i(wdt),
      .drv_disable_i(dis), .rst_int_o(rst_int), .rst_drv_o(rst_drv)
   );

   function automatic int next_run(input int run, input bit delayed_pin);
      if (!delayed_pin) return 0;
      return (run < QUAL) ? run + 1 : QUAL;
   endfunction

   function automatic int next_rem(input int rem, input bit strobe);
      if (strobe) return PULSE;
      return (rem > 0) ? rem - 1 : 0;
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick(input bit p, input bit w, input bit d);
      pin = p; wdt = w; dis = d;
      @(posedge clk);
      m_run = next_run(m_run, m_p2);
      m_p2  = m_p1;
      m_p1  = p;
      if (w) m_en = !d;
      m_rem = next_rem(m_rem, w);
      @(negedge clk);
      chk(rst_int == ((m_run == QUAL) || (m_rem > 0)), "R2/R7 model rst_int",
          int'(rst_int), int'((m_run == QUAL) || (m_rem > 0)));
      chk(rst_drv == ((m_rem > 0) && m_en), "R5/R6 model rst_drv",
          int'(rst_drv), int'((m_rem > 0) && m_en));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0);
   endtask

   // count consecutive cycles a chosen output stays high after a strobe tick
   task automatic run_window(input bit d, input bit flip_dis, output int drv_n, output int int_n);
      drv_n = 0; int_n = 0;
      tick(1'b0, 1'b1, d);
      for (int i = 0; i < 200; i++) begin
         if (rst_drv) drv_n++;
         if (rst_int) int_n++;
         tick(1'b0, 1'b0, flip_dis ? ~d : d);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int dn, inn, mx;
      void'($urandom(32'd20240611));
      m_p1 = 0; m_p2 = 0; m_en = 0; m_run = 0; m_rem = 0;
      repeat (3) @(negedge clk);
      // R1: power-on reset state
      chk(rst_int == 1'b0 && rst_drv == 1'b0, "R1 during por", int'({rst_int, rst_drv}), 0);
      por_n = 1'b1;
      @(negedge clk);
      chk(rst_int == 1'b0 && rst_drv == 1'b0, "R1 after por", int'({rst_int, rst_drv}), 0);

      // R2: 24 samples assert on edge 26, not before
      for (int i = 1; i <= 25; i++) tick(1'b1, 1'b0, 1'b0);
      chk(rst_int == 1'b0, "R2 before edge 26", int'(rst_int), 0);
      tick(1'b1, 1'b0, 1'b0);
      chk(rst_int == 1'b1, "R2 at edge 26", int'(rst_int), 1);
      // R4: release on the third low sample
      tick(1'b0, 1'b0, 1'b0);
      tick(1'b0, 1'b0, 1'b0);
      chk(rst_int == 1'b1, "R4 held after two lows", int'(rst_int), 1);
      tick(1'b0, 1'b0, 1'b0);
      chk(rst_int == 1'b0, "R4 released on third low", int'(rst_int), 0);
      idle(4);

      // R2 boundary: 23 samples never assert
      mx = 0;
      for (int i = 0; i < 23; i++) begin tick(1'b1, 1'b0, 1'b0); if (rst_int) mx = 1; end
      for (int i = 0; i < 5; i++)  begin tick(1'b0, 1'b0, 1'b0); if (rst_int) mx = 1; end
      chk(mx == 0, "R2 23 samples no reset", mx, 0);

      // R3: glitch restarts the count
      mx = 0;
      for (int i = 0; i < 20; i++) begin tick(1'b1, 1'b0, 1'b0); if (rst_int) mx = 1; end
      tick(1'b0, 1'b0, 1'b0); if (rst_int) mx = 1;
      for (int i = 0; i < 23; i++) begin tick(1'b1, 1'b0, 1'b0); if (rst_int) mx = 1; end
      for (int i = 0; i < 5; i++)  begin tick(1'b0, 1'b0, 1'b0); if (rst_int) mx = 1; end
      chk(mx == 0, "R3 glitch then 23 highs", mx, 0);
      mx = 0;
      for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, 1'b0);
      tick(1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 26; i++) begin tick(1'b1, 1'b0, 1'b0); if (rst_int) mx = 1; end
      chk(mx == 1, "R3 glitch then 24 highs", mx, 1);
      idle(5);

      // R5 / R7: enabled pulse
      run_window(1'b0, 1'b0, dn, inn);
      chk(dn == PULSE, "R5 drive length", dn, PULSE);
      chk(inn == PULSE, "R7 internal reset length", inn, PULSE);
      // R6: suppressed pulse
      run_window(1'b1, 1'b0, dn, inn);
      chk(dn == 0, "R6 no drive", dn, 0);
      chk(inn == PULSE, "R6 internal reset length", inn, PULSE);
      // R9: suppress bit raised mid-window has no effect
      run_window(1'b0, 1'b1, dn, inn);
      chk(dn == PULSE, "R9 drive kept", dn, PULSE);

      // R8: retrigger after 50 cycles
      dn = 0;
      tick(1'b0, 1'b1, 1'b0);
      if (rst_drv) dn++;
      for (int i = 0; i < 49; i++) begin tick(1'b0, 1'b0, 1'b0); if (rst_drv) dn++; end
      tick(1'b0, 1'b1, 1'b0);
      if (rst_drv) dn++;
      for (int i = 0; i < 120; i++) begin tick(1'b0, 1'b0, 1'b0); if (rst_drv) dn++; end
      chk(dn == 50 + PULSE, "R8 retrigger length", dn, 50 + PULSE);

      // random phase checked against the model inside tick
      for (int s = 0; s < 200; s++) begin
         int  len = 1 + int'($urandom % 40);
         bit  pv  = ($urandom % 4) != 0;
         bit  dv  = $urandom % 2;
         for (int i = 0; i < len; i++) tick(pv, ($urandom % 120) == 0, dv);
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule